// File: doc/BRIEF.md
# Dataflow Grid Node Execution Tile

This block is a single node of a two-dimensional ALU array. The array runs statically placed instructions in dataflow order. The node has one instruction slot per frame, and each slot carries two operand buffers. Operand values arrive on three input ports and land in the buffers of the slot they address. A select stage looks at every frame and issues a fully supplied instruction to the local integer ALU. The result is then presented on up to three output ports, each tagged with one of the consumer targets stored in the instruction.

The node has no central issue window and does no renaming. An instruction fires once its operands are present. Its result goes point to point to at most three consumers, and a single-operand pass instruction serves as the split that widens fan-out. A per-frame clear empties a slot when the block in that frame commits or is flushed. Routers, caches and block sequencing live outside the node.

Each target byte is passed through unchanged for the router. The bit layout is row [7:5], column [4:3], frame [2:1] and operand index [0]. The node only tests whether the byte is zero.

Top module: `gridNodeTile`

## Requirements
- R1: After reset all output valids are low and every frame slot is empty.
- R2: A load writes the opcode and three target bytes into the addressed frame slot, marks the slot occupied and empties both of its operand buffers.
- R3: An operand on an input port is stored only if its frame slot was occupied before that cycle. Otherwise it is dropped and never contributes to a later firing. Operand index 0 fills buffer A and index 1 fills buffer B.
- R4: An instruction whose opcode has bit 3 set needs only operand A. Any other opcode needs A and B. The instruction fires exactly once, after which its slot is empty.
- R5: Opcode encoding for the result: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 A shifted left by B[4:0], 6 A shifted right logically by B[4:0], 7 signed A<B giving 1 or 0, and 8 to 15 pass A.
- R6: On firing, output port k carries the result with target byte k, and only where that byte is nonzero. When the last operand is captured at edge e, the output valid is seen after edge e+1.
- R7: When several frames are ready in the same cycle, the lowest frame number fires first, one instruction per cycle.
- R8: An output port with valid high and ready low holds its valid, data and target. No instruction that needs such a port fires until the port drains.
- R9: A frame clear empties the slot and discards its buffered operands, so operands arriving later do not fire it. A fresh load then makes the slot usable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Load an instruction this cycle |
| loadFrame | input | FRAME_W | Frame slot to load |
| loadOpcode | input | OPC_W | Opcode of the loaded instruction |
| loadTargets | input | PORTS*TGT_W | Three consumer target bytes, byte k for output port k |
| inValid | input | PORTS | Operand present on input port p |
| inFrame | input | PORTS*FRAME_W | Frame addressed by each input port |
| inOpIdx | input | PORTS | Operand index per input port (0 = A, 1 = B) |
| inData | input | PORTS*DATA_W | Operand value per input port |
| frameClear | input | FRAMES | Per-frame slot clear |
| outReady | input | PORTS | Downstream accepts output port k |
| outValid | output | PORTS | Output port k holds a result |
| outTarget | output | PORTS*TGT_W | Consumer target byte per output port |
| outData | output | PORTS*DATA_W | Result value per output port |

## Verification
The bench sweeps every ALU operation across all frames and a rotation of input ports. The operand patterns include equal values, all-ones, zero and shift counts at the limit. A wrong opcode decode or a signed/unsigned mix-up in the compare would show up as a bad value, and a swapped A/B buffer would show up in subtraction and shifts. Zero target bytes are mixed in, so a port that forwards an unused target would raise a spurious valid. The bench makes three frames ready in the same cycle to expose a select that favours the wrong frame. It blocks an output port to catch a node that overwrites a held result or fires into a busy port. It also sends operands to empty and cleared frames, where a node that keeps stale operands would fire too early or fire an instruction that was flushed.

// File: rtl/gridNodePkg.sv
package gridNodePkg;
  localparam int PORTS = 3;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SLT  = 4'd7,
    OP_PASS = 4'd8
  } aluOp_e;

  typedef struct packed {
    logic             loadEn;
    logic             issueEn;
    logic [PORTS-1:0] opWrEn;
    logic [PORTS-1:0] portLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/gridNodeCtrl.sv
module gridNodeCtrl
  import gridNodePkg::*;
#(
  parameter int FRAMES  = 4,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          loadValid,
  input  logic [FRAME_W-1:0]            loadFrame,
  input  logic [PORTS-1:0]              inValid,
  input  logic [PORTS*FRAME_W-1:0]      inFrame,
  input  logic [PORTS-1:0]              inOpIdx,
  input  logic [FRAMES-1:0]             frameClear,
  input  logic [PORTS-1:0]              outReady,
  input  logic [FRAMES-1:0]             needsB,
  input  logic [FRAMES-1:0][PORTS-1:0]  tgtUsed,
  output logic [PORTS-1:0]              outValid,
  output logic [FRAME_W-1:0]            issueFrame,
  output ctrlStrobes_t                  stb
);
  logic [FRAMES-1:0] slotValid, opHaveA, opHaveB, ready;
  logic [PORTS-1:0]  portFree;
  logic              anyReady, portsOk;

  always_comb begin
    for (int f = 0; f < FRAMES; f++)
      ready[f] = slotValid[f] && opHaveA[f] && (opHaveB[f] || !needsB[f]);
    issueFrame = '0;
    anyReady   = 1'b0;
    for (int f = FRAMES - 1; f >= 0; f--) begin
      if (ready[f]) begin
        issueFrame = FRAME_W'(f);
        anyReady   = 1'b1;
      end
    end
    portFree = ~outValid | outReady;
    portsOk  = 1'b1;
    for (int k = 0; k < PORTS; k++)
      if (tgtUsed[issueFrame][k] && !portFree[k]) portsOk = 1'b0;
  end

  always_comb begin
    stb.loadEn   = loadValid;
    stb.issueEn  = anyReady && portsOk;
    for (int p = 0; p < PORTS; p++)
      stb.opWrEn[p] = inValid[p] && slotValid[inFrame[p*FRAME_W +: FRAME_W]];
    stb.portLoad = (anyReady && portsOk) ? tgtUsed[issueFrame] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      opHaveA   <= '0;
      opHaveB   <= '0;
      outValid  <= '0;
    end else begin
      if (loadValid) begin
        slotValid[loadFrame] <= 1'b1;
        opHaveA[loadFrame]   <= 1'b0;
        opHaveB[loadFrame]   <= 1'b0;
      end
      for (int p = 0; p < PORTS; p++) begin
        if (stb.opWrEn[p]) begin
          if (inOpIdx[p]) opHaveB[inFrame[p*FRAME_W +: FRAME_W]] <= 1'b1;
          else            opHaveA[inFrame[p*FRAME_W +: FRAME_W]] <= 1'b1;
        end
      end
      if (stb.issueEn) begin
        slotValid[issueFrame] <= 1'b0;
        opHaveA[issueFrame]   <= 1'b0;
        opHaveB[issueFrame]   <= 1'b0;
      end
      for (int f = 0; f < FRAMES; f++) begin
        if (frameClear[f]) begin
          slotValid[f] <= 1'b0;
          opHaveA[f]   <= 1'b0;
          opHaveB[f]   <= 1'b0;
        end
      end
      outValid <= (outValid & ~outReady) | stb.portLoad;
    end
  end
endmodule

// File: rtl/gridNodeDatapath.sv
module gridNodeDatapath
  import gridNodePkg::*;
#(
  parameter int FRAMES  = 4,
  parameter int DATA_W  = 32,
  parameter int TGT_W   = 8,
  parameter int OPC_W   = 4,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  stb,
  input  logic [FRAME_W-1:0]            issueFrame,
  input  logic [FRAME_W-1:0]            loadFrame,
  input  logic [OPC_W-1:0]              loadOpcode,
  input  logic [PORTS*TGT_W-1:0]        loadTargets,
  input  logic [PORTS*FRAME_W-1:0]      inFrame,
  input  logic [PORTS-1:0]              inOpIdx,
  input  logic [PORTS*DATA_W-1:0]       inData,
  output logic [FRAMES-1:0]             needsB,
  output logic [FRAMES-1:0][PORTS-1:0]  tgtUsed,
  output logic [PORTS*TGT_W-1:0]        outTarget,
  output logic [PORTS*DATA_W-1:0]       outData
);
  localparam int SH_W = $clog2(DATA_W);

  logic [OPC_W-1:0]             opcode [FRAMES];
  logic [PORTS-1:0][TGT_W-1:0]  targets [FRAMES];
  logic [DATA_W-1:0]            bufA [FRAMES];
  logic [DATA_W-1:0]            bufB [FRAMES];
  logic [DATA_W-1:0]            aluA, aluB, result;

  generate
    for (genvar f = 0; f < FRAMES; f++) begin : g_frameInfo
      assign needsB[f] = !opcode[f][OPC_W-1];
      for (genvar k = 0; k < PORTS; k++) begin : g_tgt
        assign tgtUsed[f][k] = |targets[f][k];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < FRAMES; f++) begin
        opcode[f]  <= '0;
        targets[f] <= '0;
      end
    end else if (stb.loadEn) begin
      opcode[loadFrame]  <= loadOpcode;
      targets[loadFrame] <= loadTargets;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (stb.opWrEn[p]) begin
        if (inOpIdx[p]) bufB[inFrame[p*FRAME_W +: FRAME_W]] <= inData[p*DATA_W +: DATA_W];
        else            bufA[inFrame[p*FRAME_W +: FRAME_W]] <= inData[p*DATA_W +: DATA_W];
      end
    end
  end

  assign aluA = bufA[issueFrame];
  assign aluB = bufB[issueFrame];

  always_comb begin
    if (opcode[issueFrame][OPC_W-1]) begin
      result = aluA;
    end else begin
      unique case (opcode[issueFrame][2:0])
        3'd0:    result = aluA + aluB;
        3'd1:    result = aluA - aluB;
        3'd2:    result = aluA & aluB;
        3'd3:    result = aluA | aluB;
        3'd4:    result = aluA ^ aluB;
        3'd5:    result = aluA << aluB[SH_W-1:0];
        3'd6:    result = aluA >> aluB[SH_W-1:0];
        default: result = DATA_W'($signed(aluA) < $signed(aluB));
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData   <= '0;
      outTarget <= '0;
    end else begin
      for (int k = 0; k < PORTS; k++) begin
        if (stb.portLoad[k]) begin
          outData[k*DATA_W +: DATA_W]  <= result;
          outTarget[k*TGT_W +: TGT_W]  <= targets[issueFrame][k];
        end
      end
    end
  end
endmodule

// File: rtl/gridNodeTile.sv
module gridNodeTile
  import gridNodePkg::*;
#(
  parameter int FRAMES  = 4,
  parameter int DATA_W  = 32,
  parameter int TGT_W   = 8,
  parameter int OPC_W   = 4,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      loadValid,
  input  logic [FRAME_W-1:0]        loadFrame,
  input  logic [OPC_W-1:0]          loadOpcode,
  input  logic [PORTS*TGT_W-1:0]    loadTargets,
  input  logic [PORTS-1:0]          inValid,
  input  logic [PORTS*FRAME_W-1:0]  inFrame,
  input  logic [PORTS-1:0]          inOpIdx,
  input  logic [PORTS*DATA_W-1:0]   inData,
  input  logic [FRAMES-1:0]         frameClear,
  input  logic [PORTS-1:0]          outReady,
  output logic [PORTS-1:0]          outValid,
  output logic [PORTS*TGT_W-1:0]    outTarget,
  output logic [PORTS*DATA_W-1:0]   outData
);
  ctrlStrobes_t                 ctrlStb;
  logic [FRAME_W-1:0]           issueFrame;
  logic [FRAMES-1:0]            needsB;
  logic [FRAMES-1:0][PORTS-1:0] tgtUsed;

  gridNodeCtrl #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadFrame(loadFrame),
    .inValid(inValid), .inFrame(inFrame), .inOpIdx(inOpIdx),
    .frameClear(frameClear), .outReady(outReady), .needsB(needsB),
    .tgtUsed(tgtUsed), .outValid(outValid), .issueFrame(issueFrame),
    .stb(ctrlStb)
  );

  gridNodeDatapath #(.FRAMES(FRAMES), .DATA_W(DATA_W), .TGT_W(TGT_W),
                     .OPC_W(OPC_W), .FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .issueFrame(issueFrame),
    .loadFrame(loadFrame), .loadOpcode(loadOpcode), .loadTargets(loadTargets),
    .inFrame(inFrame), .inOpIdx(inOpIdx), .inData(inData),
    .needsB(needsB), .tgtUsed(tgtUsed), .outTarget(outTarget), .outData(outData)
  );
endmodule

// File: rtl/gridNodeTileChk.sv
module gridNodeTileChk
  import gridNodePkg::*;
#(
  parameter int FRAMES  = 4,
  parameter int DATA_W  = 32,
  parameter int TGT_W   = 8,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [FRAMES-1:0]         frameClear,
  input logic [PORTS-1:0]          outReady,
  input logic [PORTS-1:0]          outValid,
  input logic [PORTS*TGT_W-1:0]    outTarget,
  input logic [PORTS*DATA_W-1:0]   outData,
  input ctrlStrobes_t              ctrlStb,
  input logic [FRAME_W-1:0]        issueFrame
);
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_idle_r1: assert (outValid == '0)
        else $error("outputs valid during reset");
    end
  end

  generate
    for (genvar k = 0; k < PORTS; k++) begin : g_port
      p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
        outValid[k] && !outReady[k] |=> outValid[k]);
      p_hold_data_r8: assert property (@(posedge clk) disable iff (!rstN)
        outValid[k] && !outReady[k] |=> $stable(outData[k*DATA_W +: DATA_W]));
      p_hold_target_r8: assert property (@(posedge clk) disable iff (!rstN)
        outValid[k] && !outReady[k] |=> $stable(outTarget[k*TGT_W +: TGT_W]));
      p_target_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
        outValid[k] |-> outTarget[k*TGT_W +: TGT_W] != '0);
    end
    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
      p_clear_no_fire_r9: assert property (@(posedge clk) disable iff (!rstN)
        frameClear[f] |=> !(ctrlStb.issueEn && issueFrame == FRAME_W'(f)));
    end
  endgenerate
endmodule

bind gridNodeTile gridNodeTileChk #(
  .FRAMES(FRAMES), .DATA_W(DATA_W), .TGT_W(TGT_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rstN(rstN), .frameClear(frameClear), .outReady(outReady),
  .outValid(outValid), .outTarget(outTarget), .outData(outData),
  .ctrlStb(ctrlStb), .issueFrame(issueFrame)
);

// File: tb/gridNodeTile_tb.sv
module gridNodeTile_tb;
  localparam int FRAMES = 4;
  localparam int DW     = 32;
  localparam int TW     = 8;
  localparam int FW     = 2;
  localparam int NP     = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            loadValid = 1'b0;
  logic [FW-1:0]   loadFrame = '0;
  logic [3:0]      loadOpcode = '0;
  logic [NP*TW-1:0] loadTargets = '0;
  logic [NP-1:0]   inValid = '0;
  logic [NP*FW-1:0] inFrame = '0;
  logic [NP-1:0]   inOpIdx = '0;
  logic [NP*DW-1:0] inData = '0;
  logic [FRAMES-1:0] frameClear = '0;
  logic [NP-1:0]   outReady = '1;
  logic [NP-1:0]   outValid;
  logic [NP*TW-1:0] outTarget;
  logic [NP*DW-1:0] outData;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  gridNodeTile u_dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadFrame(loadFrame),
    .loadOpcode(loadOpcode), .loadTargets(loadTargets), .inValid(inValid),
    .inFrame(inFrame), .inOpIdx(inOpIdx), .inData(inData),
    .frameClear(frameClear), .outReady(outReady), .outValid(outValid),
    .outTarget(outTarget), .outData(outData)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expAlu(input int op, input logic [31:0] a, input logic [31:0] b);
    if (op >= 8) return a;
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[4:0];
      6: return a >> b[4:0];
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic loadInstr(input int frame, input int op, input logic [NP*TW-1:0] tg);
    loadValid = 1'b1; loadFrame = FW'(frame); loadOpcode = 4'(op); loadTargets = tg;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic putOp(input int port, input int frame, input bit idx, input logic [31:0] d);
    inValid[port] = 1'b1;
    inFrame[port*FW +: FW] = FW'(frame);
    inOpIdx[port] = idx;
    inData[port*DW +: DW] = d;
  endtask

  task automatic endOps();
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic expectOut(input string tag, input logic [NP*TW-1:0] tg, input logic [31:0] d);
    logic [NP-1:0] mask;
    for (int k = 0; k < NP; k++) mask[k] = (tg[k*TW +: TW] != 0);
    checkEq({tag, " valid"}, 32'(outValid), 32'(mask));
    for (int k = 0; k < NP; k++) begin
      if (mask[k]) begin
        checkEq({tag, " data"}, outData[k*DW +: DW], d);
        checkEq({tag, " target"}, 32'(outTarget[k*TW +: TW]), 32'(tg[k*TW +: TW]));
      end
    end
  endtask

  task automatic expectIdle(input string tag, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      checkEq(tag, 32'(outValid), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NP*TW-1:0] tg;
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    checkEq("R1 reset valid", 32'(outValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 post-reset idle", 32'(outValid), 32'd0);

    // R5 R6 R4 R2 sweep over opcodes, frames, ports and targets
    for (int op = 0; op < 10; op++) begin
      for (int i = 0; i < 6; i++) begin
        int fr = (op + i) % FRAMES;
        a = 32'h9E3779B9 * (i + 1) + op;
        case (i)
          0: b = a;
          1: b = 32'hFFFF_FFFF;
          2: b = 32'd31;
          3: b = 32'd0;
          4: b = 32'h8000_0001;
          default: b = 32'h0000_0124 ^ (op << 3);
        endcase
        tg = {8'(8'h40 + op * 6 + i), 8'(8'h21 + i), 8'(8'h90 + op)};
        if (i % 4 == 1) tg[0 +: TW] = '0;
        if (i % 4 == 2) tg[TW +: TW] = '0;
        if (i % 4 == 3) tg[2*TW +: TW] = '0;
        loadInstr(fr, op, tg);
        putOp(i % NP, fr, 1'b0, a);
        if (op < 8) putOp((i + 1) % NP, fr, 1'b1, b);
        endOps();
        @(negedge clk);
        expectOut($sformatf("R5 R6 op%0d pat%0d", op, i), tg, expAlu(op, a, b));
        @(negedge clk);
        checkEq("R4 fires once", 32'(outValid), 32'd0);
      end
    end

    // R4: two-operand instruction waits for B
    loadInstr(0, 1, {8'h00, 8'h00, 8'h15});
    putOp(2, 0, 1'b0, 32'd1000);
    endOps();
    expectIdle("R4 waits for B", 3);
    putOp(0, 0, 1'b1, 32'd1);
    endOps();
    @(negedge clk);
    expectOut("R4 fires after B", {8'h00, 8'h00, 8'h15}, 32'd999);
    @(negedge clk);

    // R7: three frames ready together, lowest first
    for (int f = 1; f < 4; f++) loadInstr(f, 8, {8'h00, 8'h00, 8'(8'h40 + f)});
    putOp(0, 3, 1'b0, 32'd300);
    putOp(1, 1, 1'b0, 32'd100);
    putOp(2, 2, 1'b0, 32'd200);
    endOps();
    @(negedge clk);
    expectOut("R7 first frame1", {8'h00, 8'h00, 8'h41}, 32'd100);
    @(negedge clk);
    expectOut("R7 second frame2", {8'h00, 8'h00, 8'h42}, 32'd200);
    @(negedge clk);
    expectOut("R7 third frame3", {8'h00, 8'h00, 8'h43}, 32'd300);
    @(negedge clk);
    checkEq("R7 drained", 32'(outValid), 32'd0);

    // R8: blocked port holds and stalls issue
    outReady = '0;
    loadInstr(0, 8, {8'h00, 8'h00, 8'h11});
    loadInstr(1, 8, {8'h00, 8'h00, 8'h22});
    putOp(0, 0, 1'b0, 32'hAAAA_0000);
    putOp(1, 1, 1'b0, 32'hBBBB_0000);
    endOps();
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      expectOut("R8 held while not ready", {8'h00, 8'h00, 8'h11}, 32'hAAAA_0000);
      @(negedge clk);
    end
    outReady = '1;
    @(negedge clk);
    expectOut("R8 stalled issue resumes", {8'h00, 8'h00, 8'h22}, 32'hBBBB_0000);
    @(negedge clk);
    checkEq("R8 drained", 32'(outValid), 32'd0);

    // R9: clear discards buffered operand and slot
    loadInstr(2, 0, {8'h00, 8'h33, 8'h00});
    putOp(0, 2, 1'b0, 32'd7);
    endOps();
    frameClear = 4'b0100;
    @(negedge clk);
    frameClear = '0;
    putOp(1, 2, 1'b1, 32'd5);
    endOps();
    expectIdle("R9 cleared frame stays silent", 3);
    loadInstr(2, 0, {8'h00, 8'h33, 8'h00});
    putOp(1, 2, 1'b1, 32'd5);
    endOps();
    expectIdle("R9 no stale A after reload", 2);
    putOp(2, 2, 1'b0, 32'd7);
    endOps();
    @(negedge clk);
    expectOut("R9 reload fires", {8'h00, 8'h33, 8'h00}, 32'd12);
    @(negedge clk);

    // R3: operand to an empty frame is dropped
    putOp(0, 3, 1'b0, 32'hDEAD_BEEF);
    endOps();
    loadInstr(3, 9, {8'h61, 8'h62, 8'h63});
    expectIdle("R3 dropped operand", 3);
    putOp(2, 3, 1'b0, 32'h0BAD_F00D);
    endOps();
    @(negedge clk);
    expectOut("R3 fresh operand fires", {8'h61, 8'h62, 8'h63}, 32'h0BAD_F00D);
    @(negedge clk);

    // R2: reload overwrites and empties operands
    loadInstr(1, 2, {8'h00, 8'h00, 8'h71});
    putOp(0, 1, 1'b0, 32'hF0F0_F0F0);
    endOps();
    loadInstr(1, 3, {8'h72, 8'h00, 8'h00});
    putOp(1, 1, 1'b1, 32'h0000_000F);
    endOps();
    expectIdle("R2 reload empties operands", 2);
    putOp(0, 1, 1'b0, 32'h1230_0000);
    endOps();
    @(negedge clk);
    expectOut("R2 reloaded opcode used", {8'h72, 8'h00, 8'h00}, 32'h1230_000F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule